// File: doc/BRIEF.md
# Two-of-Four Serial Pattern Detector

This block watches a serial bit stream and raises a one-cycle-resolution flag whenever exactly two of the four most recent bits are ones. Three past bits are held in a short shift register. The fourth bit of the window is the bit being sampled on the current clock edge, so the default build answers in the same edge that takes the bit, in Mealy form. The decision is then captured in an output flip-flop so that gate-level transition glitches never reach the pin.

Two build-time choices are available. The first picks how the match is formed: a population count compared against the target, or even parity of the window masked by an all-ones term and an all-zeros term. For a four-bit window with a target of two, both give the same answer. The second inserts a synchronizing flip-flop on the input, giving a Moore form that uses only registered bits. That form reports the same results one clock later.

Top module: `twoOfFourDetect`

## Requirements
- R1: While `rst` is high at a rising edge, `flagOut` is 0 after that edge and all stored history is cleared. After reset the window behaves as all zeros: the first bit after reset, if it is a 1, gives a flag of 0.
- R2: In the default (live input) form, after rising edge k, `flagOut` is 1 exactly when the bit sampled at edge k together with the three bits sampled at edges k-1, k-2 and k-3 holds exactly two ones. With a present bit of 0 that means two ones among the stored three; with a present bit of 1 it means one.
- R3: A window of four ones gives `flagOut` = 0.
- R4: A window of four zeros gives `flagOut` = 0.
- R5: With `SYNC_IN` = 1, `flagOut` after edge k equals the value the default form shows after edge k-1 for the same stream.
- R6: The counting style (`DETECT_STYLE` = DET_COUNT, encoding 0) and the gated-parity style (DET_PARITY, encoding 1, the default) produce identical `flagOut` sequences.
- R7: The newest bit enters window position 0 and the oldest bit is dropped each clock. After the bits 1,0,0,0,1 the first 1 no longer counts and the flag is 0. A further 1 then gives a flag of 1.
- R8: `flagOut` changes only at rising edges. Toggling `serIn` between edges has no effect on `flagOut` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial data bit, sampled each rising edge |
| flagOut | output | 1 | Registered flag: exactly two ones in the four-bit window |

## Verification
The hardest case to reach from the ports is a window whose combinational match flips between edges while the registered output must hold. The stimulus sets up a two-ones history, drives a bit that makes the window match, and then briefly inverts the input mid-cycle before restoring it. The flag is checked to stay put through the inversion. A second hard case is a reset issued while ones are still held in the history. The stimulus loads ones and resets mid-stream, then shows that the first 1 after reset does not combine with any stale bit.

// File: rtl/twoOfFourPkg.sv
package twoOfFourPkg;

  typedef enum logic {
    DET_COUNT  = 1'b0,
    DET_PARITY = 1'b1
  } detStyle_e;

  typedef struct packed {
    logic clearAll;
    logic shiftEn;
    logic loadFlag;
  } detStrobe_t;

endpackage

// File: rtl/twoOfFourCtrl.sv
module twoOfFourCtrl
  import twoOfFourPkg::*;
(
  input  logic       rst,
  output detStrobe_t strobes
);

  always_comb begin
    strobes.clearAll = rst;
    strobes.shiftEn  = ~rst;
    strobes.loadFlag = ~rst;
  end

endmodule

// File: rtl/twoOfFourMatch.sv
module twoOfFourMatch
  import twoOfFourPkg::*;
#(
  parameter int        WIN_LEN  = 4,
  parameter int        HIT_ONES = 2,
  parameter detStyle_e STYLE    = DET_PARITY
) (
  input  logic [WIN_LEN-1:0] window,
  output logic               hit
);

  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam bit PARITY_OK = (STYLE == DET_PARITY) && (WIN_LEN == 4) && (HIT_ONES == 2);

  generate
    if (PARITY_OK) begin : g_parity
      logic evenPar;
      logic notAllOnes;
      logic notAllZeros;
      always_comb begin
        evenPar     = ~(^window);
        notAllOnes  = ~(&window);
        notAllZeros = |window;
        hit         = evenPar & notAllOnes & notAllZeros;
      end
    end else begin : g_count
      logic [CNT_W-1:0] ones;
      always_comb begin
        ones = '0;
        for (int i = 0; i < WIN_LEN; i++) begin
          ones = ones + CNT_W'(window[i]);
        end
        hit = (ones == CNT_W'(HIT_ONES));
      end
    end
  endgenerate

endmodule

// File: rtl/twoOfFourDp.sv
module twoOfFourDp
  import twoOfFourPkg::*;
#(
  parameter int        WIN_LEN  = 4,
  parameter int        HIT_ONES = 2,
  parameter detStyle_e STYLE    = DET_PARITY,
  parameter bit        SYNC_IN  = 1'b0
) (
  input  logic       clk,
  input  detStrobe_t strobes,
  input  logic       serIn,
  output logic       flagOut
);

  localparam int HIST_LEN = WIN_LEN - 1;

  logic                curBit;
  logic [HIST_LEN-1:0] histQ;
  logic [WIN_LEN-1:0]  window;
  logic                hitComb;
  logic                flagQ;

  generate
    if (SYNC_IN) begin : g_sync
      logic syncQ;
      always_ff @(posedge clk) begin
        if (strobes.clearAll)     syncQ <= 1'b0;
        else if (strobes.shiftEn) syncQ <= serIn;
      end
      assign curBit = syncQ;
    end else begin : g_live
      assign curBit = serIn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clearAll)     histQ <= '0;
    else if (strobes.shiftEn) histQ <= {histQ[HIST_LEN-2:0], curBit};
  end

  assign window = {histQ, curBit};

  twoOfFourMatch #(
    .WIN_LEN (WIN_LEN),
    .HIT_ONES(HIT_ONES),
    .STYLE   (STYLE)
  ) u_match (
    .window(window),
    .hit   (hitComb)
  );

  always_ff @(posedge clk) begin
    if (strobes.clearAll)      flagQ <= 1'b0;
    else if (strobes.loadFlag) flagQ <= hitComb;
  end

  assign flagOut = flagQ;

endmodule

// File: rtl/twoOfFourDetect.sv
module twoOfFourDetect
  import twoOfFourPkg::*;
#(
  parameter int        WIN_LEN      = 4,
  parameter int        HIT_ONES     = 2,
  parameter detStyle_e DETECT_STYLE = DET_PARITY,
  parameter bit        SYNC_IN      = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic serIn,
  output logic flagOut
);

  detStrobe_t strobes;

  twoOfFourCtrl u_ctrl (
    .rst    (rst),
    .strobes(strobes)
  );

  twoOfFourDp #(
    .WIN_LEN (WIN_LEN),
    .HIT_ONES(HIT_ONES),
    .STYLE   (DETECT_STYLE),
    .SYNC_IN (SYNC_IN)
  ) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .serIn  (serIn),
    .flagOut(flagOut)
  );

endmodule

// File: rtl/twoOfFourChk.sv
module twoOfFourChk #(
  parameter bit SYNC_IN = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic serIn,
  input logic flagOut
);

  logic [3:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                    sinceRst <= '0;
    else if (sinceRst != 4'hF)  sinceRst <= sinceRst + 4'd1;
  end

  // R1
  reset_clears_flag_chk: assert property (@(posedge clk) rst |=> !flagOut);

  generate
    if (SYNC_IN) begin : g_moore
      // R5
      moore_window_chk: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 4'd6) |-> (flagOut == ($countones({$past(serIn,2), $past(serIn,3),
                                                         $past(serIn,4), $past(serIn,5)}) == 2)));
      // R3
      moore_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ((sinceRst >= 4'd6) && $past(serIn,2) && $past(serIn,3) && $past(serIn,4) && $past(serIn,5))
        |-> !flagOut);
      // R4
      moore_all_zeros_chk: assert property (@(posedge clk) disable iff (rst)
        ((sinceRst >= 4'd6) && !$past(serIn,2) && !$past(serIn,3) && !$past(serIn,4) && !$past(serIn,5))
        |-> !flagOut);
    end else begin : g_mealy
      // R2
      mealy_window_chk: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 4'd5) |-> (flagOut == ($countones({$past(serIn,1), $past(serIn,2),
                                                         $past(serIn,3), $past(serIn,4)}) == 2)));
      // R3
      mealy_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ((sinceRst >= 4'd5) && $past(serIn,1) && $past(serIn,2) && $past(serIn,3) && $past(serIn,4))
        |-> !flagOut);
      // R4
      mealy_all_zeros_chk: assert property (@(posedge clk) disable iff (rst)
        ((sinceRst >= 4'd5) && !$past(serIn,1) && !$past(serIn,2) && !$past(serIn,3) && !$past(serIn,4))
        |-> !flagOut);
    end
  endgenerate

endmodule

bind twoOfFourDetect twoOfFourChk #(.SYNC_IN(SYNC_IN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .serIn  (serIn),
  .flagOut(flagOut)
);

// File: tb/test_twoOfFourDetect.sv
module test_twoOfFourDetect;
  import twoOfFourPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_BITS  = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b1;
  logic flagPar, flagCnt, flagSync;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] hist = 4'b0;
  logic       prevMealy = 1'b0;
  logic       expMealy[$];
  logic       expMoore[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  twoOfFourDetect i_twoOfFourDetect (
    .clk(clk), .rst(rst), .serIn(serIn), .flagOut(flagPar)
  );

  twoOfFourDetect #(.DETECT_STYLE(DET_COUNT)) i_twoOfFourDetectCnt (
    .clk(clk), .rst(rst), .serIn(serIn), .flagOut(flagCnt)
  );

  twoOfFourDetect #(.SYNC_IN(1'b1)) i_twoOfFourDetectSync (
    .clk(clk), .rst(rst), .serIn(serIn), .flagOut(flagSync)
  );

  task automatic checkEq(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: drives one bit at the falling edge and queues expected flags
  task automatic sendBit(input logic b, input bit probe);
    logic m;
    logic held;
    @(negedge clk);
    serIn = b;
    hist = {hist[2:0], b};
    m = ($countones(hist) == 2);
    expMealy.push_back(m);
    expMoore.push_back(prevMealy);
    prevMealy = m;
    if (probe) begin
      #1;
      held = flagPar;
      serIn = ~b;
      #1;
      checkEq("R8", "flag held while input toggles", flagPar, held);
      serIn = b;
    end
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serIn = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1", "live flag in reset", flagPar, 1'b0);
    checkEq("R1", "count flag in reset", flagCnt, 1'b0);
    checkEq("R1", "sync flag in reset", flagSync, 1'b0);
    rst = 1'b0;
    serIn = 1'b0;
    hist = 4'b0;
    prevMealy = 1'b0;
  endtask

  // Monitor: pops expected flags just after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (expMealy.size() > 0) begin
      logic e;
      e = expMealy.pop_front();
      checkEq("R2", "live flag vs window model", flagPar, e);
      checkEq("R6", "count style vs parity style", flagCnt, flagPar);
    end
    if (expMoore.size() > 0) begin
      logic e2;
      e2 = expMoore.pop_front();
      checkEq("R5", "sync flag one cycle behind", flagSync, e2);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    checkEq("R1", "live flag at reset", flagPar, 1'b0);
    checkEq("R1", "sync flag at reset", flagSync, 1'b0);
    rst = 1'b0;
    serIn = 1'b0;

    // R1: first 1 after reset sees zeros
    sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R1", "first one after reset", flagPar, 1'b0);
    sendBit(1'b0, 1'b0); sendBit(1'b0, 1'b0); sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R7", "oldest bit dropped", flagPar, 1'b0);
    sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R7", "newest pair counted", flagPar, 1'b1);

    // R3: all ones
    for (int i = 0; i < 6; i++) sendBit(1'b1, 1'b0);
    afterEdge();
    checkEq("R3", "all ones window", flagPar, 1'b0);
    // R4: all zeros
    for (int i = 0; i < 6; i++) sendBit(1'b0, 1'b0);
    afterEdge();
    checkEq("R4", "all zeros window", flagPar, 1'b0);

    // R2: present 0 with two stored ones
    sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0); sendBit(1'b0, 1'b1);
    afterEdge();
    checkEq("R2", "present 0 two stored ones", flagPar, 1'b1);
    // R2: present 1 with one stored one
    sendBit(1'b0, 1'b0); sendBit(1'b0, 1'b0); sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b1); afterEdge();
    checkEq("R2", "present 1 one stored one", flagPar, 1'b1);

    // R5: sync form lags by one edge
    for (int i = 0; i < 4; i++) sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R5", "sync not yet raised", flagSync, 1'b0);
    checkEq("R2", "live raised", flagPar, 1'b1);
    sendBit(1'b0, 1'b0); afterEdge();
    checkEq("R5", "sync raised one edge later", flagSync, 1'b1);

    // Alternating and paired patterns
    for (int i = 0; i < 16; i++) sendBit(i[0], 1'b1);
    for (int i = 0; i < 16; i++) sendBit(i[1], 1'b1);

    // R1: reset with ones in history
    sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0);
    doReset();
    sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R1", "stale history cleared", flagPar, 1'b0);
    checkEq("R1", "stale history cleared sync", flagSync, 1'b0);
    sendBit(1'b1, 1'b0); afterEdge();
    checkEq("R2", "pair after reset", flagPar, 1'b1);

    // Random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < RAND_BITS; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendBit(lfsr[0], (i % 7) == 3);
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule